// File: doc/BRIEF.md
# Masked Device Interrupt Router

This block collects interrupt requests from up to 64 device sources into one shared raw request vector and fans them out to four processors. Every processor owns a 64-bit mask. Its pending vector is the bitwise AND of that mask with the shared raw vector. Each processor receives a level interrupt line that is high while any of its pending bits is set.

Devices drive the raw vector with single-cycle raise and clear pulses. Each pulse carries a 6-bit source index. Software reaches the block through a simple request port that only accepts full 64-bit accesses. Through that port it writes and reads back the masks, and it reads the pending vectors and the raw vector. A mask write can raise or drop a processor's line on its own, with no change at any source.

Top module: `irq_router`

## Requirements
- R1: After reset every mask and the raw vector are zero, and `irq_o`, `ack_o`, `err_o` and `rdata_o` are all low.
- R2: A raise pulse for source index n sets bit n of the raw vector at that clock edge.
- R3: A clear pulse for source index n clears bit n of the raw vector. A clear for a bit that is already zero is spurious and leaves the raw vector unchanged.
- R4: When a raise and a clear name the same source in the same cycle, the bit ends up set.
- R5: Reading the pending vector of processor c returns the bitwise AND of mask c and the raw vector, as they stood before the access edge.
- R6: `irq_o[c]` is a register. In the cycle after any edge it equals the OR-reduction of mask c AND raw as they stood before that edge. It follows both source pulses and mask writes.
- R7: A legal write to mask offset c replaces all 64 bits of mask c at that edge. A later read of the same offset returns the written value.
- R8: The register offset is `addr_i >> 6`, and the low six address bits are ignored. Offsets 0 to 3 are the masks of processors 0 to 3. Offsets 4 to 7 are their pending vectors. Offset 8 is the raw vector.
- R9: Some accesses are illegal: a `size_i` other than 3 (3 means eight bytes), an offset above 8, or a write to offsets 4 to 8. An illegal access pulses `err_o` for one cycle after the request edge. It returns zero data and changes no mask.
- R10: A legal access pulses `ack_o` for one cycle after the request edge. For a read, `rdata_o` carries the value in that same cycle and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_set_i | input | 1 | Raise pulse for one source |
| src_set_idx_i | input | 6 | Source index of the raise pulse |
| src_clr_i | input | 1 | Clear pulse for one source |
| src_clr_idx_i | input | 6 | Source index of the clear pulse |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 means write, 0 means read |
| addr_i | input | 12 | Byte offset within the block |
| size_i | input | 2 | Access size as log2 of bytes; only 3 is legal |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid while `ack_o` is high |
| ack_o | output | 1 | Legal access completed |
| err_o | output | 1 | Illegal access rejected |
| irq_o | output | 4 | Level interrupt for each processor |

## Verification
The reference model is driven with single raises and clears at the edge indices 0 and 63. It also sees spurious clears and same-index raise/clear collisions. These separate a correct bit update from an off-by-one or a wrong priority. Mask writes with disjoint, overlapping and all-ones patterns show that each processor's line depends only on its own mask. They also show that removing a mask bit drops the line while the raw bit stays set. Illegal sizes, out-of-range offsets, writes to read-only offsets and nonzero low address bits test the decode. A long run of mixed random traffic is checked against the model on every clock.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned OFS_LSB = 6;
  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } acc_size_e;
endpackage

// File: rtl/irq_raw_vec.sv
module irq_raw_vec #(
  parameter int unsigned IDX_W = 6,
  localparam int unsigned N    = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [N-1:0]     raw_o
);
  logic [N-1:0] raw_q, raw_d;

  // clear applied first so a same-index raise wins
  always_comb begin
    raw_d = raw_q;
    if (clr_i) raw_d[clr_idx_i] = 1'b0;
    if (set_i) raw_d[set_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= raw_d;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned N       = 64,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [CPU_W-1:0]   wr_cpu_i,
  input  logic [N-1:0]       wr_data_i,
  input  logic [N-1:0]       raw_i,
  output logic [NUM_CPU*N-1:0] mask_o,
  output logic [NUM_CPU*N-1:0] pend_o,
  output logic [NUM_CPU-1:0] irq_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [N-1:0] mask_q;
    logic         irq_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q <= '0;
        irq_q  <= 1'b0;
      end else begin
        if (wr_en_i && wr_cpu_i == CPU_W'(c)) mask_q <= wr_data_i;
        irq_q <= |(mask_q & raw_i);
      end
    end

    assign mask_o[c*N +: N] = mask_q;
    assign pend_o[c*N +: N] = mask_q & raw_i;
    assign irq_o[c]         = irq_q;
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned N       = 64,
  parameter int unsigned ADDR_W  = 12,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned OFS_W  = ADDR_W - OFS_LSB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           size_i,
  input  logic [N-1:0]         wdata_i,
  input  logic [NUM_CPU*N-1:0] mask_i,
  input  logic [NUM_CPU*N-1:0] pend_i,
  input  logic [N-1:0]         raw_i,
  output logic                 wr_en_o,
  output logic [CPU_W-1:0]     wr_cpu_o,
  output logic [N-1:0]         wr_data_o,
  output logic [N-1:0]         rdata_o,
  output logic                 ack_o,
  output logic                 err_o
);
  localparam logic [OFS_W-1:0] PEND_BASE = OFS_W'(NUM_CPU);
  localparam logic [OFS_W-1:0] RAW_OFS   = OFS_W'(2 * NUM_CPU);

  logic [OFS_W-1:0] ofs;
  logic             unused_low;
  logic             size_ok, is_mask, legal;
  logic [N-1:0]     rd_d, rdata_q;
  logic             ack_q, err_q;

  assign ofs        = addr_i[ADDR_W-1:OFS_LSB];
  assign unused_low = ^addr_i[OFS_LSB-1:0];
  assign size_ok    = (size_i == SZ_8B);
  assign is_mask    = (ofs < PEND_BASE);
  assign legal      = size_ok && (is_mask || (!we_i && ofs <= RAW_OFS));

  assign wr_en_o   = req_i && we_i && legal;
  assign wr_cpu_o  = CPU_W'(ofs);
  assign wr_data_o = wdata_i;

  always_comb begin
    rd_d = '0;
    if (ofs == RAW_OFS) rd_d = raw_i;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (ofs == OFS_W'(c))           rd_d = mask_i[c*N +: N];
      if (ofs == OFS_W'(NUM_CPU + c)) rd_d = pend_i[c*N +: N];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req_i && legal;
      err_q   <= req_i && !legal;
      rdata_q <= (req_i && legal && !we_i) ? rd_d : '0;
    end
  end

  assign ack_o   = ack_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned SRC_IDX_W = 6,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned N        = 1 << SRC_IDX_W,
  localparam int unsigned CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 src_set_i,
  input  logic [SRC_IDX_W-1:0] src_set_idx_i,
  input  logic                 src_clr_i,
  input  logic [SRC_IDX_W-1:0] src_clr_idx_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           size_i,
  input  logic [N-1:0]         wdata_i,
  output logic [N-1:0]         rdata_o,
  output logic                 ack_o,
  output logic                 err_o,
  output logic [NUM_CPU-1:0]   irq_o
);
  logic [N-1:0]         raw;
  logic [NUM_CPU*N-1:0] mask, pend;
  logic                 wr_en;
  logic [CPU_W-1:0]     wr_cpu;
  logic [N-1:0]         wr_data;

  irq_raw_vec #(.IDX_W(SRC_IDX_W)) u_raw (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (src_set_i),
    .set_idx_i (src_set_idx_i),
    .clr_i     (src_clr_i),
    .clr_idx_i (src_clr_idx_i),
    .raw_o     (raw)
  );

  irq_mask_bank #(.NUM_CPU(NUM_CPU), .N(N)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_cpu_i  (wr_cpu),
    .wr_data_i (wr_data),
    .raw_i     (raw),
    .mask_o    (mask),
    .pend_o    (pend),
    .irq_o     (irq_o)
  );

  irq_reg_port #(.NUM_CPU(NUM_CPU), .N(N), .ADDR_W(ADDR_W)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .size_i    (size_i),
    .wdata_i   (wdata_i),
    .mask_i    (mask),
    .pend_i    (pend),
    .raw_i     (raw),
    .wr_en_o   (wr_en),
    .wr_cpu_o  (wr_cpu),
    .wr_data_o (wr_data),
    .rdata_o   (rdata_o),
    .ack_o     (ack_o),
    .err_o     (err_o)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned SRC_IDX_W = 6,
  localparam int unsigned N        = 1 << SRC_IDX_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 src_set_i,
  input logic [SRC_IDX_W-1:0] src_set_idx_i,
  input logic                 src_clr_i,
  input logic [SRC_IDX_W-1:0] src_clr_idx_i,
  input logic                 req_i,
  input logic [1:0]           size_i,
  input logic                 ack_o,
  input logic                 err_o,
  input logic [NUM_CPU-1:0]   irq_o,
  input logic [N-1:0]         raw,
  input logic [NUM_CPU*N-1:0] mask
);
  logic [NUM_CPU-1:0] any_pend;
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_any
    assign any_pend[c] = |(mask[c*N +: N] & raw);
  end

  p_raise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_set_i |=> raw[$past(src_set_idx_i)]);

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_clr_i && !(src_set_i && src_set_idx_i == src_clr_idx_i)) |=> !raw[$past(src_clr_idx_i)]);

  p_raise_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_set_i && src_clr_i && src_set_idx_i == src_clr_idx_i) |=> raw[$past(src_clr_idx_i)]);

  p_irq_track_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (irq_o == $past(any_pend)));

  p_bad_size_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != 2'd3) |=> (err_o && !ack_o));

  p_err_keeps_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(mask));

  p_ack_err_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && err_o));
endmodule

bind irq_router irq_router_chk #(.NUM_CPU(NUM_CPU), .SRC_IDX_W(SRC_IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .src_set_i     (src_set_i),
  .src_set_idx_i (src_set_idx_i),
  .src_clr_i     (src_clr_i),
  .src_clr_idx_i (src_clr_idx_i),
  .req_i         (req_i),
  .size_i        (size_i),
  .ack_o         (ack_o),
  .err_o         (err_o),
  .irq_o         (irq_o),
  .raw           (raw),
  .mask          (mask)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_v = 1'b0, clr_v = 1'b0;
  logic [5:0]  set_idx = '0, clr_idx = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  size = 2'd3;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        ack, err;
  logic [3:0]  irq;

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  irq_router dut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_set_i(set_v), .src_set_idx_i(set_idx),
    .src_clr_i(clr_v), .src_clr_idx_i(clr_idx),
    .req_i(req), .we_i(we), .addr_i(addr), .size_i(size), .wdata_i(wdata),
    .rdata_o(rdata), .ack_o(ack), .err_o(err), .irq_o(irq)
  );

  // behavioural reference model
  logic [63:0] m_mask [4];
  logic [63:0] m_raw;
  logic [3:0]  e_irq;
  logic        e_ack, e_err;
  logic [63:0] e_rd;
  string       e_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) m_mask[c] = '0;
      m_raw = '0; e_irq = '0; e_ack = 0; e_err = 0; e_rd = '0; e_tag = "R1";
    end else begin
      int o;
      e_tag = cur_tag;
      for (int c = 0; c < 4; c++) e_irq[c] = |(m_mask[c] & m_raw);
      e_ack = 0; e_err = 0; e_rd = '0;
      if (req) begin
        o = int'(addr) / 64;
        if (size != 2'd3 || o > 8 || (we && o >= 4)) e_err = 1;
        else begin
          e_ack = 1;
          if (we) m_mask[o] = wdata;
          else if (o < 4) e_rd = m_mask[o];
          else if (o < 8) e_rd = m_mask[o-4] & m_raw;
          else e_rd = m_raw;
        end
      end
      if (clr_v) m_raw[clr_idx] = 1'b0;
      if (set_v) m_raw[set_idx] = 1'b1;
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", e_tag, what, act, exp);
    end
  endtask

  // compared on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk("irq (R6)", 64'(irq), 64'(e_irq));
    chk("ack (R10)", 64'(ack), 64'(e_ack));
    chk("err (R9)", 64'(err), 64'(e_err));
    chk("rdata", rdata, e_rd);
  end

  task automatic idle();
    req = 0; we = 0; set_v = 0; clr_v = 0; size = 2'd3;
    @(negedge clk);
  endtask
  task automatic wr(input string t, input int o, input logic [63:0] d);
    cur_tag = t; req = 1; we = 1; addr = 12'(o * 64); size = 2'd3; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask
  task automatic rd(input string t, input int o);
    cur_tag = t; req = 1; we = 0; addr = 12'(o * 64); size = 2'd3;
    @(negedge clk); req = 0;
  endtask
  task automatic raise(input string t, input int i);
    cur_tag = t; set_v = 1; set_idx = 6'(i); @(negedge clk); set_v = 0;
  endtask
  task automatic lower(input string t, input int i);
    cur_tag = t; clr_v = 1; clr_idx = 6'(i); @(negedge clk); clr_v = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state via reads
    rd("R1", 8); rd("R1", 0); rd("R1", 3); idle();
    // R7 R8: mask writes and readback
    wr("R7", 0, 64'h0000_0000_0000_0001);
    wr("R7", 1, 64'h8000_0000_0000_0000);
    wr("R7", 2, 64'hFFFF_FFFF_FFFF_FFFF);
    wr("R7", 3, 64'h0000_0000_0000_0020);
    for (int c = 0; c < 4; c++) rd("R7", c);
    // R2 R6: raise edge indices
    raise("R2", 0); idle(); rd("R2", 8);
    raise("R2", 63); idle(); rd("R5", 4); rd("R5", 5); rd("R5", 6); rd("R5", 7);
    raise("R6", 5); idle(); idle();
    // R6: mask removal drops line while raw stays
    wr("R6", 3, 64'h0); idle(); rd("R6", 8);
    wr("R6", 3, 64'h20); idle();
    // R3: clear and spurious clear
    lower("R3", 5); idle(); rd("R3", 8);
    lower("R3", 17); idle(); rd("R3", 8);
    // R4: collision raise wins
    cur_tag = "R4"; set_v = 1; clr_v = 1; set_idx = 6'd40; clr_idx = 6'd40;
    @(negedge clk); set_v = 0; clr_v = 0; rd("R4", 8);
    // R8: low address bits ignored
    cur_tag = "R8"; req = 1; we = 0; addr = 12'h23F; size = 2'd3;
    @(negedge clk); req = 0; idle();
    // R9: illegal accesses leave masks unchanged
    cur_tag = "R9"; req = 1; we = 1; addr = 12'h000; size = 2'd2; wdata = '1;
    @(negedge clk); req = 0; we = 0; rd("R9", 0);
    rd("R9", 9); rd("R9", 63);
    wr("R9", 4, 64'hDEAD); wr("R9", 8, 64'hBEEF); rd("R9", 4); rd("R9", 8);
    // mixed random traffic
    for (int k = 0; k < 600; k++) begin
      cur_tag = "R5";
      set_v = ($urandom % 3) == 0; set_idx = 6'($urandom);
      clr_v = ($urandom % 3) == 0; clr_idx = ($urandom % 4 == 0) ? set_idx : 6'($urandom);
      req = ($urandom % 2) == 0; we = ($urandom % 3) == 0;
      addr = 12'(($urandom % 11) * 64 + ($urandom % 64));
      size = ($urandom % 8 == 0) ? 2'($urandom) : 2'd3;
      wdata = {$urandom, $urandom};
      @(negedge clk);
    end
    idle(); idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule